// File: doc/BRIEF.md
# Load Address and Byte Extension Unit

This unit sits in the load path of a processor pipeline and does two jobs. First, it forms the address sent to memory for a load request and the updated value of the base register. It takes a base operand and an offset, and it can add the offset to the base or subtract it. The offset comes from a 12-bit immediate, from an index operand, or from an index operand shifted left by 0 to 3 places. Three base-update modes exist:

- **Offset mode** leaves the base register alone.
- **Pre-indexed mode** uses the adjusted base as the address and writes that same value back.
- **Post-indexed mode** sends the untouched base to memory and writes the adjusted base back.

Second, the unit turns the byte returned by memory into a full 32-bit register value. It uses zero fill or sign fill, and the result is presented one clock after the read byte is marked valid.

The address path is purely combinational. Decode supplies the mode, source and direction selects, and the register file supplies the operands. The writeback enable tells the register file whether to update the base register in the same cycle.

Top module: `agu_load_unit`

## Requirements
- R1: With `addr_mode` = 0 (offset), `eff_addr` equals base plus or minus the selected offset and `wb_en` is 0.
- R2: With `addr_mode` = 1 (pre-indexed), `eff_addr` equals base plus or minus the offset, `wb_val` equals that same value, and `wb_en` equals `req_valid`.
- R3: With `addr_mode` = 2 (post-indexed), `eff_addr` equals the unmodified base, `wb_val` equals base plus or minus the offset, and `wb_en` equals `req_valid`.
- R4: `off_src` selects the offset as follows:
  - 0 gives `imm_val` zero-extended to 32 bits.
  - 1 gives `index_val`.
  - 2 gives `index_val` shifted left by `shift_amt` (0 to 3), with bits moved past bit 31 dropped.
  - 3 behaves like 0.
- R5: `sub_off` = 1 subtracts the offset and `sub_off` = 0 adds it. All address arithmetic wraps modulo 2^32 with no error indication.
- R6: `wb_en` is 0 whenever `req_valid` is 0, in every mode. `addr_mode` = 3 behaves exactly like offset mode.
- R7: An unsigned load (`ld_signed` = 0) yields the byte in bits 7:0 with bits 31:8 all zero.
- R8: A signed load (`ld_signed` = 1) yields the byte in bits 7:0 with bits 31:8 all equal to bit 7 of the byte.
- R9: Timing of the load result:
  - On the rising edge where `rdata_valid` is 1, `ld_result` takes the extended byte and `ld_result_valid` becomes 1 for that cycle.
  - On an edge where `rdata_valid` is 0, `ld_result` holds its value and `ld_result_valid` is 0.
- R10: While `rst` is high at a rising edge, `ld_result` and `ld_result_valid` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A load request is presented this cycle |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value |
| imm_val | input | 12 | Immediate offset, zero-extended |
| shift_amt | input | 2 | Left shift applied to the index in shifted-index source |
| off_src | input | 2 | Offset source: 0 immediate, 1 index, 2 shifted index, 3 immediate |
| addr_mode | input | 2 | Base-update mode: 0 offset, 1 pre-indexed, 2 post-indexed, 3 offset |
| sub_off | input | 1 | 1 subtracts the offset, 0 adds it |
| ld_signed | input | 1 | 1 sign-extends the read byte, 0 zero-extends it |
| rdata_valid | input | 1 | Read byte is valid this cycle |
| rdata_byte | input | 8 | Byte returned by memory |
| eff_addr | output | 32 | Address sent to memory |
| wb_en | output | 1 | Write the base register this cycle |
| wb_val | output | 32 | Updated base value |
| ld_result | output | 32 | Extended load data |
| ld_result_valid | output | 1 | `ld_result` was updated at the last edge |

## Verification
The hardest case to reach is one where the mode, the offset source and the direction meet an address wrap. An example is a subtraction that crosses zero while in post-indexed mode, where the address must stay at the base while only the writeback value wraps. The stimulus sweeps every combination of mode, source, shift, direction and request valid. It does this over four operand sets chosen so that additions cross 2^32, subtractions cross zero, and shifts push set bits past bit 31. For the extension path, every byte value is sent with both signedness settings, followed by an idle cycle that must leave the result untouched.

// File: rtl/agu_pkg.sv
package agu_pkg;

    localparam int XLEN   = 32;
    localparam int IMM_W  = 12;
    localparam int SHAMT_W = 2;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        AM_OFFSET = 2'd0,
        AM_PRE    = 2'd1,
        AM_POST   = 2'd2,
        AM_RSVD   = 2'd3
    } addr_mode_e;

    typedef enum logic [1:0] {
        OS_IMM     = 2'd0,
        OS_REG     = 2'd1,
        OS_REG_SHL = 2'd2,
        OS_RSVD    = 2'd3
    } off_src_e;

    function automatic logic [XLEN-1:0] adjust_base(
        input logic [XLEN-1:0] base,
        input logic [XLEN-1:0] off,
        input logic            sub
    );
        return sub ? (base - off) : (base + off);
    endfunction

    function automatic logic [XLEN-1:0] widen_byte(
        input logic [BYTE_W-1:0] b,
        input logic              sgn
    );
        logic fill;
        fill = sgn & b[BYTE_W-1];
        return {{(XLEN-BYTE_W){fill}}, b};
    endfunction

endpackage

// File: rtl/agu_offset_sel.sv
module agu_offset_sel
    import agu_pkg::*;
#(
    parameter int DATA_W = XLEN,
    parameter int IW     = IMM_W,
    parameter int SW     = SHAMT_W
) (
    input  logic [1:0]        off_src,
    input  logic [DATA_W-1:0] index_val,
    input  logic [IW-1:0]     imm_val,
    input  logic [SW-1:0]     shift_amt,
    output logic [DATA_W-1:0] offset
);
    localparam int PAD_W = DATA_W - IW;

    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] idx_shl;
    off_src_e          src;

    assign imm_ext = {{PAD_W{1'b0}}, imm_val};
    assign idx_shl = index_val << shift_amt;
    assign src     = off_src_e'(off_src);

    always_comb begin
        unique case (src)
            OS_REG:     offset = index_val;
            OS_REG_SHL: offset = idx_shl;
            default:    offset = imm_ext;
        endcase
    end

    // immediate sources never produce bits above the immediate field (R4)
    always_comb begin
        if (src == OS_IMM || src == OS_RSVD)
            p_imm_upper_zero_r4: assert (offset[DATA_W-1:IW] == '0)
                else $error("immediate offset has upper bits set");
    end

endmodule

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
    import agu_pkg::*;
#(
    parameter int DATA_W = XLEN
) (
    input  logic [DATA_W-1:0] base_val,
    input  logic [DATA_W-1:0] offset,
    input  logic              sub_off,
    input  logic [1:0]        addr_mode,
    input  logic              req_valid,
    output logic [DATA_W-1:0] eff_addr,
    output logic              wb_en,
    output logic [DATA_W-1:0] wb_val
);
    logic [DATA_W-1:0] adjusted;
    addr_mode_e        mode;
    logic              updates_base;

    assign adjusted = adjust_base(base_val, offset, sub_off);
    assign mode     = addr_mode_e'(addr_mode);

    always_comb begin
        unique case (mode)
            AM_PRE:  begin eff_addr = adjusted; updates_base = 1'b1; end
            AM_POST: begin eff_addr = base_val; updates_base = 1'b1; end
            default: begin eff_addr = adjusted; updates_base = 1'b0; end
        endcase
    end

    assign wb_en  = updates_base & req_valid;
    assign wb_val = adjusted;

endmodule

// File: rtl/agu_byte_ext.sv
module agu_byte_ext
    import agu_pkg::*;
#(
    parameter int DATA_W = XLEN,
    parameter int BW     = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rdata_valid,
    input  logic              ld_signed,
    input  logic [BW-1:0]     rdata_byte,
    output logic [DATA_W-1:0] ld_result,
    output logic              ld_result_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ld_result       <= '0;
            ld_result_valid <= 1'b0;
        end else begin
            ld_result_valid <= rdata_valid;
            if (rdata_valid)
                ld_result <= widen_byte(rdata_byte, ld_signed);
        end
    end

    p_low_byte_r9: assert property (@(posedge clk) disable iff (rst)
        rdata_valid |=> (ld_result[BW-1:0] == $past(rdata_byte)) && ld_result_valid);

    p_zero_fill_r7: assert property (@(posedge clk) disable iff (rst)
        (rdata_valid && !ld_signed) |=> (ld_result[DATA_W-1:BW] == '0));

    p_sign_fill_r8: assert property (@(posedge clk) disable iff (rst)
        (rdata_valid && ld_signed) |=>
            (ld_result[DATA_W-1:BW] == {(DATA_W-BW){$past(rdata_byte[BW-1])}}));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !rdata_valid |=> $stable(ld_result) && !ld_result_valid);

endmodule

// File: rtl/agu_load_unit.sv
module agu_load_unit
    import agu_pkg::*;
#(
    parameter int DATA_W = XLEN,
    parameter int IW     = IMM_W,
    parameter int SW     = SHAMT_W,
    parameter int BW     = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [DATA_W-1:0] base_val,
    input  logic [DATA_W-1:0] index_val,
    input  logic [IW-1:0]     imm_val,
    input  logic [SW-1:0]     shift_amt,
    input  logic [1:0]        off_src,
    input  logic [1:0]        addr_mode,
    input  logic              sub_off,
    input  logic              ld_signed,
    input  logic              rdata_valid,
    input  logic [BW-1:0]     rdata_byte,
    output logic [DATA_W-1:0] eff_addr,
    output logic              wb_en,
    output logic [DATA_W-1:0] wb_val,
    output logic [DATA_W-1:0] ld_result,
    output logic              ld_result_valid
);
    logic [DATA_W-1:0] offset;

    agu_offset_sel #(.DATA_W(DATA_W), .IW(IW), .SW(SW)) u_off (
        .off_src   (off_src),
        .index_val (index_val),
        .imm_val   (imm_val),
        .shift_amt (shift_amt),
        .offset    (offset)
    );

    agu_addr_calc #(.DATA_W(DATA_W)) u_calc (
        .base_val  (base_val),
        .offset    (offset),
        .sub_off   (sub_off),
        .addr_mode (addr_mode),
        .req_valid (req_valid),
        .eff_addr  (eff_addr),
        .wb_en     (wb_en),
        .wb_val    (wb_val)
    );

    agu_byte_ext #(.DATA_W(DATA_W), .BW(BW)) u_ext (
        .clk             (clk),
        .rst             (rst),
        .rdata_valid     (rdata_valid),
        .ld_signed       (ld_signed),
        .rdata_byte      (rdata_byte),
        .ld_result       (ld_result),
        .ld_result_valid (ld_result_valid)
    );

    p_no_wb_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !wb_en);

    p_offset_no_wb_r1: assert property (@(posedge clk) disable iff (rst)
        (addr_mode == 2'd0 || addr_mode == 2'd3) |-> !wb_en);

    p_pre_same_r2: assert property (@(posedge clk) disable iff (rst)
        (addr_mode == 2'd1) |-> (eff_addr == wb_val) && (wb_en == req_valid));

    p_post_base_r3: assert property (@(posedge clk) disable iff (rst)
        (addr_mode == 2'd2) |-> (eff_addr == base_val) && (wb_en == req_valid));

    p_zero_offset_r5: assert property (@(posedge clk) disable iff (rst)
        (off_src == 2'd0 && imm_val == '0) |-> (wb_val == base_val));

endmodule

// File: tb/tb_agu_load_unit.sv
`timescale 1ns/100ps
module tb_agu_load_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] base_val, index_val;
    logic [11:0] imm_val;
    logic [1:0]  shift_amt, off_src, addr_mode;
    logic        sub_off, ld_signed, rdata_valid;
    logic [7:0]  rdata_byte;
    logic [31:0] eff_addr, wb_val, ld_result;
    logic        wb_en, ld_result_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    agu_load_unit dut (
        .clk(clk), .rst(rst), .req_valid(req_valid),
        .base_val(base_val), .index_val(index_val), .imm_val(imm_val),
        .shift_amt(shift_amt), .off_src(off_src), .addr_mode(addr_mode),
        .sub_off(sub_off), .ld_signed(ld_signed), .rdata_valid(rdata_valid),
        .rdata_byte(rdata_byte), .eff_addr(eff_addr), .wb_en(wb_en),
        .wb_val(wb_val), .ld_result(ld_result), .ld_result_valid(ld_result_valid)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    logic [31:0] bases [4];
    logic [31:0] idxs  [4];
    logic [11:0] imms  [4];

    initial begin
        bases[0] = 32'h1000_0000; idxs[0] = 32'h0000_0010; imms[0] = 12'h005;
        bases[1] = 32'h0000_0004; idxs[1] = 32'hC000_0001; imms[1] = 12'hFFF;
        bases[2] = 32'hFFFF_FFF0; idxs[2] = 32'h8000_0021; imms[2] = 12'h020;
        bases[3] = 32'h0000_0000; idxs[3] = 32'h7FFF_FFFF; imms[3] = 12'h000;

        rst = 1'b1; req_valid = 0; base_val = 0; index_val = 0; imm_val = 0;
        shift_amt = 0; off_src = 0; addr_mode = 0; sub_off = 0;
        ld_signed = 0; rdata_valid = 0; rdata_byte = 0;

        // R10: reset state, with a valid byte offered during reset
        @(negedge clk);
        rdata_valid = 1'b1; rdata_byte = 8'hA5;
        @(negedge clk);
        check(ld_result == 32'h0, "R10 result", ld_result, 32'h0);
        check(ld_result_valid == 1'b0, "R10 valid", {31'b0, ld_result_valid}, 32'h0);
        rdata_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1..R6: full sweep of the address path
        for (int d = 0; d < 4; d++)
        for (int m = 0; m < 4; m++)
        for (int s = 0; s < 4; s++)
        for (int sh = 0; sh < 4; sh++)
        for (int sb = 0; sb < 2; sb++)
        for (int rv = 0; rv < 2; rv++) begin
            logic [31:0] off, adj, exp_addr;
            logic        exp_wb;
            string       tag;
            @(negedge clk);
            base_val = bases[d]; index_val = idxs[d]; imm_val = imms[d];
            addr_mode = 2'(m); off_src = 2'(s); shift_amt = 2'(sh);
            sub_off = sb[0]; req_valid = rv[0];
            #1;
            case (s)
                1: off = idxs[d];
                2: off = idxs[d] << sh;   // R4 dropped high bits
                default: off = {20'h0, imms[d]};
            endcase
            adj = sb[0] ? bases[d] - off : bases[d] + off;   // R5 wraps mod 2^32
            exp_addr = (m == 2) ? bases[d] : adj;
            exp_wb   = (m == 1 || m == 2) && rv[0];
            tag = (m == 1) ? "R2" : (m == 2) ? "R3" : "R1";
            check(eff_addr == exp_addr, {tag, "/R4/R5 eff_addr"}, eff_addr, exp_addr);
            check(wb_en == exp_wb, {tag, "/R6 wb_en"}, {31'b0, wb_en}, {31'b0, exp_wb});
            if (m == 1 || m == 2)
                check(wb_val == adj, {tag, " wb_val"}, wb_val, adj);
        end
        req_valid = 1'b0;

        // R7, R8, R9: every byte in both extension modes
        for (int sg = 0; sg < 2; sg++)
        for (int b = 0; b < 256; b++) begin
            logic [31:0] exp_r;
            @(negedge clk);
            rdata_valid = 1'b1; rdata_byte = 8'(b); ld_signed = sg[0];
            exp_r = (sg == 1 && b >= 128) ? (32'hFFFF_FF00 | 32'(b)) : 32'(b);
            @(negedge clk);
            rdata_valid = 1'b0;
            check(ld_result == exp_r, sg ? "R8 sign fill" : "R7 zero fill", ld_result, exp_r);
            check(ld_result_valid, "R9 valid pulse", {31'b0, ld_result_valid}, 32'h1);
        end

        // R9: idle cycle holds the result
        @(negedge clk);
        rdata_byte = 8'h11; ld_signed = 1'b0;
        check(ld_result == 32'hFFFF_FFFF, "R9 hold", ld_result, 32'hFFFF_FFFF);
        check(!ld_result_valid, "R9 valid low", {31'b0, ld_result_valid}, 32'h0);
        @(negedge clk);
        check(ld_result == 32'hFFFF_FFFF, "R9 hold 2", ld_result, 32'hFFFF_FFFF);

        // R10: reset clears a loaded result
        rst = 1'b1;
        @(negedge clk);
        check(ld_result == 32'h0, "R10 clear", ld_result, 32'h0);
        rst = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule